// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarm

The block is a real-time clock peripheral on a simple memory-mapped register bus. It has a select and a write strobe, a 12-bit byte address and 32-bit data. A 32-bit seconds counter advances by one on every cycle in which the one-pulse-per-second tick input is high. It wraps from all ones to zero. Software can load the counter, program a match value and enable a single alarm interrupt. The oscillator and prescaler that produce the tick sit outside the block.

The alarm is an equality compare between the counter and the match value. The compare is evaluated only one cycle after an event that could change its result: a tick, a load write or a match write. When it holds, a raw status bit is set. The interrupt output is that bit ANDed with a one-bit mask. Because the compare is plain equality on a wrapping counter, a match value below the current count fires only after the counter has wrapped.

The top eight words of the 4 KB window hold a fixed identification byte table. Reads are combinational in the cycle of the strobe, and register writes take effect at the clock edge. An access to an offset that is not decoded pulses an error output in the following cycle.

Top module: `rtcSecAlarm`

## Requirements
- R1: After synchronous reset the count, match, load and mask registers all read 0, raw status reads 0 and the interrupt is low.
- R2: Each cycle with the tick high and no load write adds one to the count. 0xFFFFFFFF wraps to 0. A read of byte offset 0x00 returns the current count.
- R3: A write to offset 0x08 sets the count to the written data. A read of 0x08 returns the last value written there. When a tick and a load write fall in the same cycle, the loaded value is kept and the tick is dropped.
- R4: Offset 0x04 holds the match value (read/write). Bit 0 of offset 0x14 is raw status. It becomes 1 one cycle after the tick that makes the count equal to the match value, and not before.
- R5: A match write or load write that leaves the count equal to the match value sets raw status one cycle later, with no tick needed.
- R6: The compare is equality on the wrapping counter. A match value below the count sets raw status only after the counter wraps and climbs to it.
- R7: Offset 0x10 is the mask. A write keeps only data bit 0, and reads return that bit. The interrupt output and the read of offset 0x18 both equal raw status AND mask.
- R8: Any write to offset 0x1C clears raw status, whatever the data. Raw status then stays 0 while the count still equals the match value, until a new tick, load write or match write occurs.
- R9: Offset 0x0C always reads 1, and writes to it change nothing.
- R10: Word reads from 0xFE0 up to 0xFFC return, in address order, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended to 32 bits.
- R11: Writes to offsets 0x00, 0x14 and 0x18 have no effect, and a read of 0x1C returns 0.
- R12: Any other offset (word index 8 up to 0x3F7) reads 0 and ignores writes. The error output is high for exactly the one cycle after such an access, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickPulse | input | 1 | One-cycle pulse per second |
| busSel | input | 1 | Access strobe for this window |
| busWrite | input | 1 | 1 = write, 0 = read (with busSel) |
| busAddr | input | 12 | Byte address in the window; bits 1:0 ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the strobe cycle |
| alarmIrq | output | 1 | Level interrupt: raw status AND mask |
| accessErr | output | 1 | One-cycle pulse after an undecoded access |

## Verification
A stale or wrong count shows on the next read of offset 0x00. It also shows a few ticks later as an alarm that arrives early, late or not at all. A compare-pending flag stuck low loses the immediate alarm after a load or match write. Stuck high, it re-raises raw status right after a clear while the count still matches, which is visible at the interrupt within one cycle. A mask or raw bit in the wrong state differs at the interrupt pin in the very next cycle, so the bench compares the interrupt and error outputs every cycle against its own model and checks every read against the same model.

// File: rtl/rtcPkg.sv
package rtcPkg;

  // Word indices of the decoded registers (byte offset / 4)
  localparam int unsigned W_COUNT  = 0;
  localparam int unsigned W_MATCH  = 1;
  localparam int unsigned W_LOAD   = 2;
  localparam int unsigned W_CTRL   = 3;
  localparam int unsigned W_MASK   = 4;
  localparam int unsigned W_RAW    = 5;
  localparam int unsigned W_MASKED = 6;
  localparam int unsigned W_CLEAR  = 7;
  localparam int unsigned REG_WORDS = 8;
  localparam int unsigned ID_WORDS  = 8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_MATCH,
    SEL_LOAD,
    SEL_CTRL,
    SEL_MASK,
    SEL_RAW,
    SEL_MASKED,
    SEL_ID
  } rdSel_e;

  typedef struct packed {
    logic   loadWr;
    logic   matchWr;
    logic   maskWr;
    logic   clearWr;
    logic   badAccess;
    rdSel_e rdSel;
    logic [2:0] idIdx;
  } ctrlStrobes_t;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = 8'h31;
      3'd1: b = 8'h10;
      3'd2: b = 8'h14;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int ID_BASE = (1 << WORD_W) - ID_WORDS;

  logic [WORD_W-1:0] wordIdx;
  logic              isReg;
  logic              isId;
  logic              doWrite;
  logic              doRead;
  logic              unusedAddrBits;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = ^busAddr[1:0];
  assign isReg          = wordIdx < WORD_W'(REG_WORDS);
  assign isId           = wordIdx >= WORD_W'(ID_BASE);
  assign doWrite        = busSel && busWrite;
  assign doRead         = busSel && !busWrite;

  always_comb begin
    strobes           = '0;
    strobes.rdSel     = SEL_NONE;
    strobes.idIdx     = wordIdx[2:0];
    strobes.badAccess = busSel && !isReg && !isId;
    if (doWrite && isReg) begin
      strobes.loadWr  = wordIdx == WORD_W'(W_LOAD);
      strobes.matchWr = wordIdx == WORD_W'(W_MATCH);
      strobes.maskWr  = wordIdx == WORD_W'(W_MASK);
      strobes.clearWr = wordIdx == WORD_W'(W_CLEAR);
    end
    if (doRead) begin
      if (isId) begin
        strobes.rdSel = SEL_ID;
      end else if (isReg) begin
        case (wordIdx[2:0])
          3'(W_COUNT):  strobes.rdSel = SEL_COUNT;
          3'(W_MATCH):  strobes.rdSel = SEL_MATCH;
          3'(W_LOAD):   strobes.rdSel = SEL_LOAD;
          3'(W_CTRL):   strobes.rdSel = SEL_CTRL;
          3'(W_MASK):   strobes.rdSel = SEL_MASK;
          3'(W_RAW):    strobes.rdSel = SEL_RAW;
          3'(W_MASKED): strobes.rdSel = SEL_MASKED;
          default:      strobes.rdSel = SEL_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rtcSecCounter.sv
module rtcSecCounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickPulse,
  input  logic             loadWr,
  input  logic             matchWr,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] matchVal,
  output logic [CNT_W-1:0] countVal,
  output logic             matchHit
);

  logic cmpPending;

  // Load has priority over the tick in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      countVal <= '0;
    end else if (loadWr) begin
      countVal <= loadVal;
    end else if (tickPulse) begin
      countVal <= countVal + CNT_W'(1);
    end
  end

  // Any event that can change the compare result arms one evaluation
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpPending <= 1'b0;
    end else begin
      cmpPending <= tickPulse || loadWr || matchWr;
    end
  end

  assign matchHit = cmpPending && (countVal == matchVal);

endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickPulse,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq,
  output logic              accessErr,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] matchVal,
  output logic              maskVal,
  output logic              rawVal
);

  logic [DATA_W-1:0] loadReg;
  logic              matchHit;

  rtcSecCounter #(.CNT_W(DATA_W)) i_counter (
    .clk      (clk),
    .rst      (rst),
    .tickPulse(tickPulse),
    .loadWr   (strobes.loadWr),
    .matchWr  (strobes.matchWr),
    .loadVal  (wrData),
    .matchVal (matchVal),
    .countVal (countVal),
    .matchHit (matchHit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      loadReg  <= '0;
      matchVal <= '0;
      maskVal  <= 1'b0;
    end else begin
      if (strobes.loadWr)  loadReg  <= wrData;
      if (strobes.matchWr) matchVal <= wrData;
      if (strobes.maskWr)  maskVal  <= wrData[0];
    end
  end

  // A fresh match event outranks a clear landing in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rawVal <= 1'b0;
    end else if (matchHit) begin
      rawVal <= 1'b1;
    end else if (strobes.clearWr) begin
      rawVal <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) accessErr <= 1'b0;
    else     accessErr <= strobes.badAccess;
  end

  assign alarmIrq = rawVal && maskVal;

  always_comb begin
    case (strobes.rdSel)
      SEL_COUNT:  rdData = countVal;
      SEL_MATCH:  rdData = matchVal;
      SEL_LOAD:   rdData = loadReg;
      SEL_CTRL:   rdData = DATA_W'(1);
      SEL_MASK:   rdData = DATA_W'(maskVal);
      SEL_RAW:    rdData = DATA_W'(rawVal);
      SEL_MASKED: rdData = DATA_W'(rawVal && maskVal);
      SEL_ID:     rdData = DATA_W'(idByte(strobes.idIdx));
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/rtcSecAlarm.sv
module rtcSecAlarm
  import rtcPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickPulse,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmIrq,
  output logic              accessErr
);

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] matchVal;
  logic              maskVal;
  logic              rawVal;

  rtcCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  rtcDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .tickPulse(tickPulse),
    .wrData   (busWdata),
    .strobes  (strobes),
    .rdData   (busRdata),
    .alarmIrq (alarmIrq),
    .accessErr(accessErr),
    .countVal (countVal),
    .matchVal (matchVal),
    .maskVal  (maskVal),
    .rawVal   (rawVal)
  );

endmodule

// File: rtl/rtcChecker.sv
module rtcChecker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tickPulse,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              alarmIrq,
  input logic              accessErr,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] matchVal,
  input logic              maskVal,
  input logic              rawVal
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] chkWord;
  logic chkDefined, wrLoad, wrMatch, wrClear, rdCtrl, rdClear;

  assign chkWord    = busAddr[ADDR_W-1:2];
  assign chkDefined = (chkWord < WORD_W'(8)) || (chkWord >= WORD_W'((1 << WORD_W) - 8));
  assign wrLoad     = busSel && busWrite && chkWord == WORD_W'(2);
  assign wrMatch    = busSel && busWrite && chkWord == WORD_W'(1);
  assign wrClear    = busSel && busWrite && chkWord == WORD_W'(7);
  assign rdCtrl     = busSel && !busWrite && chkWord == WORD_W'(3);
  assign rdClear    = busSel && !busWrite && chkWord == WORD_W'(7);

  assert_tick_adds_one_R2: assert property (@(posedge clk) disable iff (rst)
    (tickPulse && !wrLoad) |=> countVal == $past(countVal) + DATA_W'(1));

  assert_load_sets_count_R3: assert property (@(posedge clk) disable iff (rst)
    wrLoad |=> countVal == $past(busWdata));

  assert_raw_rises_on_equal_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rawVal) |-> $past(countVal == matchVal));

  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
    alarmIrq |-> (maskVal && rawVal));

  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (rst)
    (wrClear && !$past(tickPulse) && !$past(wrLoad) && !$past(wrMatch)) |=> !rawVal);

  assert_ctrl_reads_one_R9: assert property (@(posedge clk) disable iff (rst)
    rdCtrl |-> busRdata == DATA_W'(1));

  assert_clear_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rdClear |-> busRdata == '0);

  assert_undef_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (busSel && !busWrite && !chkDefined) |-> busRdata == '0);

  assert_err_after_undef_R12: assert property (@(posedge clk) disable iff (rst)
    (busSel && !chkDefined) |=> accessErr);

  assert_err_only_after_undef_R12: assert property (@(posedge clk) disable iff (rst)
    !(busSel && !chkDefined) |=> !accessErr);

endmodule

bind rtcSecAlarm rtcChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
  .clk      (clk),
  .rst      (rst),
  .tickPulse(tickPulse),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .alarmIrq (alarmIrq),
  .accessErr(accessErr),
  .countVal (countVal),
  .matchVal (matchVal),
  .maskVal  (maskVal),
  .rawVal   (rawVal)
);

// File: tb/test_rtcSecAlarm.sv
`timescale 1ns/1ps
module test_rtcSecAlarm;

  localparam logic [11:0] A_CNT = 12'h000, A_MAT = 12'h004, A_LD  = 12'h008,
                          A_CTL = 12'h00C, A_MSK = 12'h010, A_RAW = 12'h014,
                          A_MIS = 12'h018, A_CLR = 12'h01C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tickPulse = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        alarmIrq;
  logic        accessErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic [31:0] mCnt = '0, mMatch = '0, mLoad = '0;
  logic        mMask = 1'b0, mRaw = 1'b0, mPend = 1'b0, mErr = 1'b0;

  always #4 clk = ~clk;

  rtcSecAlarm i_rtcSecAlarm (
    .clk(clk), .rst(rst), .tickPulse(tickPulse), .busSel(busSel),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .alarmIrq(alarmIrq), .accessErr(accessErr)
  );

  function automatic logic [7:0] expId(input int i);
    logic [7:0] t [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic bit isBad(input logic [11:0] a);
    return !((a[11:2] < 10'd8) || (a[11:2] >= 10'h3F8));
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    if (a[11:2] >= 10'h3F8) return {24'h0, expId(int'(a[4:2]))};
    case (a[11:2])
      10'd0:   return mCnt;
      10'd1:   return mMatch;
      10'd2:   return mLoad;
      10'd3:   return 32'd1;
      10'd4:   return {31'h0, mMask};
      10'd5:   return {31'h0, mRaw};
      10'd6:   return {31'h0, mRaw & mMask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    if (a[11:2] >= 10'h3F8) return "R10";
    case (a[11:2])
      10'd0:   return "R2";
      10'd1:   return "R4";
      10'd2:   return "R3";
      10'd3:   return "R9";
      10'd4:   return "R7";
      10'd5:   return "R4";
      10'd6:   return "R7";
      10'd7:   return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic tk, input logic sel, input logic wr,
                       input logic [11:0] a, input logic [31:0] d);
    tickPulse = tk; busSel = sel; busWrite = wr; busAddr = a; busWdata = d;
  endtask

  task automatic modelStep(input logic tk, input logic sel, input logic wr,
                           input logic [11:0] a, input logic [31:0] d);
    bit lw, mw, kw, cw;
    lw = sel && wr && a[11:2] == 10'd2;
    mw = sel && wr && a[11:2] == 10'd1;
    kw = sel && wr && a[11:2] == 10'd4;
    cw = sel && wr && a[11:2] == 10'd7;
    if (mPend && mCnt == mMatch) mRaw = 1'b1;
    else if (cw)                 mRaw = 1'b0;
    if (lw) begin mCnt = d; mLoad = d; end
    else if (tk) mCnt = mCnt + 32'd1;
    if (mw) mMatch = d;
    if (kw) mMask = d[0];
    mPend = lw || mw || tk;
    mErr  = sel && isBad(a);
  endtask

  // finish the cycle: edge, model update, per-cycle output checks at negedge
  task automatic tail(input logic tk, input logic sel, input logic wr,
                      input logic [11:0] a, input logic [31:0] d);
    @(posedge clk);
    modelStep(tk, sel, wr, a, d);
    @(negedge clk);
    drive(0, 0, 0, '0, '0);
    check("R7", {31'h0, alarmIrq}, {31'h0, mRaw & mMask});
    check("R12", {31'h0, accessErr}, {31'h0, mErr});
  endtask

  task automatic doCycle(input logic tk, input logic sel, input logic wr,
                         input logic [11:0] a, input logic [31:0] d);
    drive(tk, sel, wr, a, d);
    #1;
    if (sel && !wr) check(tagFor(a), busRdata, modelRead(a));
    tail(tk, sel, wr, a, d);
  endtask

  task automatic expectRead(input string tag, input logic [11:0] a, input logic [31:0] e);
    drive(0, 1, 0, a, '0);
    #1;
    check(tag, busRdata, e);
    tail(0, 1, 0, a, '0);
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    doCycle(0, 1, 1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) doCycle(1, 0, 0, '0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) doCycle(0, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", {31'h0, alarmIrq}, 32'h0);
    expectRead("R1", A_CNT, 0);
    expectRead("R1", A_MAT, 0);
    expectRead("R1", A_LD, 0);
    expectRead("R1", A_MSK, 0);
    expectRead("R1", A_RAW, 0);
    expectRead("R1", A_MIS, 0);

    // R9 control reads one, writes ignored
    expectRead("R9", A_CTL, 1);
    wrReg(A_CTL, 32'h0);
    expectRead("R9", A_CTL, 1);

    // R10 identification table
    for (int i = 0; i < 8; i++)
      expectRead("R10", 12'hFE0 + 12'(4 * i), {24'h0, expId(i)});

    // R3 load and load-over-tick
    wrReg(A_LD, 32'd100);
    expectRead("R3", A_CNT, 32'd100);
    expectRead("R3", A_LD, 32'd100);
    doCycle(1, 1, 1, A_LD, 32'd50);
    expectRead("R3", A_CNT, 32'd50);

    // R4 tick reaches match
    wrReg(A_MAT, 32'd55);
    ticks(4);
    expectRead("R4", A_RAW, 0);
    ticks(1);
    idle(1);
    expectRead("R4", A_RAW, 1);
    expectRead("R7", A_MIS, 0);

    // R7 mask keeps bit 0
    wrReg(A_MSK, 32'hFFFF_FFFE);
    expectRead("R7", A_MSK, 0);
    wrReg(A_MSK, 32'h3);
    check("R7", {31'h0, alarmIrq}, 32'h1);
    expectRead("R7", A_MSK, 1);
    expectRead("R7", A_MIS, 1);

    // R8 clear with zero data, stays clear while count still matches
    wrReg(A_CLR, 32'h0);
    idle(3);
    expectRead("R8", A_RAW, 0);
    check("R8", {31'h0, alarmIrq}, 32'h0);

    // R5 immediate alarm on match write and on load write
    wrReg(A_MAT, 32'd55);
    idle(1);
    expectRead("R5", A_RAW, 1);
    wrReg(A_CLR, 32'hFFFF_FFFF);
    expectRead("R5", A_RAW, 0);
    wrReg(A_LD, 32'd55);
    idle(1);
    expectRead("R5", A_RAW, 1);
    wrReg(A_CLR, 32'h1);

    // R6 and R2 wrap behaviour
    wrReg(A_MAT, 32'd5);
    wrReg(A_LD, 32'd10);
    ticks(3);
    expectRead("R6", A_RAW, 0);
    wrReg(A_LD, 32'hFFFF_FFFE);
    ticks(2);
    expectRead("R2", A_CNT, 32'd0);
    expectRead("R6", A_RAW, 0);
    ticks(5);
    idle(1);
    expectRead("R6", A_RAW, 1);
    wrReg(A_CLR, 32'h0);

    // R11 ignored writes, clear offset reads zero
    wrReg(A_CNT, 32'h1234);
    expectRead("R11", A_CNT, 32'd5);
    wrReg(A_RAW, 32'h1);
    expectRead("R11", A_RAW, 0);
    wrReg(A_MIS, 32'h1);
    expectRead("R11", A_MIS, 0);
    expectRead("R11", A_CLR, 0);

    // R12 undefined offsets
    expectRead("R12", 12'h020, 0);
    check("R12", {31'h0, accessErr}, 32'h1);
    idle(1);
    check("R12", {31'h0, accessErr}, 32'h0);
    wrReg(12'h400, 32'hFFFF_FFFF);
    expectRead("R12", A_MAT, 32'd5);
    expectRead("R12", A_CNT, 32'd5);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic tk;
      int op;
      logic [31:0] d;
      tk = ($urandom % 3) == 0;
      op = int'($urandom % 16);
      d  = $urandom;
      case (op)
        6: doCycle(tk, 1, 1, A_LD, (d[0]) ? d : mMatch - 32'($urandom % 3));
        7: doCycle(tk, 1, 1, A_MAT, (d[0]) ? d : mCnt + 32'($urandom % 4));
        8: doCycle(tk, 1, 1, A_MSK, d);
        9: doCycle(tk, 1, 1, A_CLR, d);
        10: doCycle(tk, 1, 0, {7'($urandom % 8), 5'h0} >> 3, 32'h0);
        11: doCycle(tk, 1, 1, 12'(($urandom % 1024) * 4), d);
        12: doCycle(tk, 1, 0, 12'(($urandom % 1024) * 4), 32'h0);
        13: doCycle(tk, 1, 0, A_RAW, 32'h0);
        14: doCycle(tk, 1, 0, A_CNT, 32'h0);
        15: doCycle(tk, 1, 0, A_MIS, 32'h0);
        default: doCycle(tk, 0, 0, '0, '0);
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule